// File: doc/BRIEF.md
# Paired General Register File

This block holds six 8-bit general registers, B, C, D, E, H and L, together with a hidden 16-bit scratch pair W/Z. Software-visible registers can be read and written one byte at a time through a 3-bit code. The same storage can also be read and written as three 16-bit pairs, with the first-named register as the high byte.

A pair can be stepped up or down by one, which makes it usable as an address pointer. The HL pair is always presented on a dedicated output so that it can serve as the pointer for indirect memory operands.

A one-command exchange swaps the contents of DE and HL. The exchange uses the scratch pair: DE goes into W/Z, HL goes into DE, and then W/Z goes into HL. It takes three clock cycles, and busy stays high for the whole of that time.

Top module: `pair_regfile`

## Requirements
- R1: A synchronous active-high reset clears all eight bytes of storage and drops busy; after reset every pair read and the pointer output return 0x0000.
- R2: Byte codes are B=000, C=001, D=010, E=011, H=100 and L=101. A byte write with code 110 or 111 changes nothing. A byte read with code 110 or 111 returns 0x00, so W and Z are never visible.
- R3: Pair codes are BC=00, DE=01 and HL=10, and the first-named register is the high byte. A pair write or pair step with code 11 changes nothing, and a pair read with code 11 returns 0x0000.
- R4: The pointer output always equals the current HL pair.
- R5: When a register is written, a read of that byte or of its pair in the same cycle returns the old value. The new value appears from the next cycle on.
- R6: A step adds one (up) or subtracts one (down) from the selected pair modulo 65536, so 0xFFFF+1 gives 0x0000 and 0x0000-1 gives 0xFFFF.
- R7: A start request accepted while idle raises busy for exactly three cycles. When busy falls, DE holds the former HL, HL holds the former DE, and BC is unchanged.
- R8: While busy, and in the cycle a start is accepted, byte writes, pair writes, steps and further start requests are ignored.
- R9: When several updates arrive in the same idle cycle, a step takes priority over a pair write, and a pair write takes priority over a byte write. Only the winning update takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write request |
| wr_sel | input | 3 | Byte write code |
| wr_data | input | 8 | Byte write value |
| rd_sel | input | 3 | Byte read code |
| rd_data | output | 8 | Byte read value (combinational) |
| pw_en | input | 1 | Pair write request |
| pw_sel | input | 2 | Pair write code |
| pw_data | input | 16 | Pair write value, high byte first-named |
| pr_sel | input | 2 | Pair read code |
| pr_data | output | 16 | Pair read value (combinational) |
| step_en | input | 1 | Pair step request |
| step_sel | input | 2 | Pair step code |
| step_dn | input | 1 | 1 = step down, 0 = step up |
| xchg_start | input | 1 | Request a DE/HL exchange |
| busy | output | 1 | Exchange in progress |
| hl_ptr | output | 16 | Current HL pair |

## Verification
The properties assume that reset is held for at least one clock edge before any request. They also assume that request inputs are stable around the rising edge. Beyond that they allow any mix of requests, including out-of-range codes and requests issued while busy. The stimulus drives every input on the falling edge and releases every request one cycle later. It deliberately issues writes, steps and start requests during an exchange and in the same cycle as a start, so that the ignore rules are exercised. The exchange checks compare against values the stimulus itself placed in DE and HL.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
    localparam int BYTE_W = 8;
    localparam int PAIR_W = 2 * BYTE_W;
    localparam int SEL_W  = 3;
    localparam int PSEL_W = SEL_W - 1;
    localparam int NREG   = 1 << SEL_W;
    localparam int NVIS   = 6;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [PAIR_W-1:0] pair_t;

    typedef enum logic [SEL_W-1:0] {
        IX_B = 3'd0, IX_C = 3'd1, IX_D = 3'd2, IX_E = 3'd3,
        IX_H = 3'd4, IX_L = 3'd5, IX_W = 3'd6, IX_Z = 3'd7
    } reg_ix_e;

    localparam logic [PSEL_W-1:0] PR_DE = 2'd1;
    localparam logic [PSEL_W-1:0] PR_HL = 2'd2;
    localparam logic [PSEL_W-1:0] PR_WZ = 2'd3;

    typedef enum logic [1:0] {
        XS_IDLE = 2'd0,
        XS_LOAD = 2'd1,
        XS_MOVE = 2'd2,
        XS_BACK = 2'd3
    } xphase_e;

    typedef struct packed {
        logic          hit;
        logic [PSEL_W-1:0] sel;
        pair_t         val;
    } pair_upd_t;

    function automatic logic byte_code_ok(input logic [SEL_W-1:0] c);
        return int'(c) < NVIS;
    endfunction

    function automatic logic pair_code_ok(input logic [PSEL_W-1:0] c);
        return c != PR_WZ;
    endfunction

    function automatic logic [SEL_W-1:0] pair_hi(input logic [PSEL_W-1:0] p);
        return {p, 1'b0};
    endfunction

    function automatic logic [SEL_W-1:0] pair_lo(input logic [PSEL_W-1:0] p);
        return {p, 1'b1};
    endfunction
endpackage

// File: rtl/rp_bank.sv
module rp_bank
    import regpair_pkg::*;
#(
    parameter int N = NREG,
    parameter int W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N-1:0]      we,
    input  logic [N-1:0][W-1:0] wd,
    output logic [N-1:0][W-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                q[i] <= '0;
            end else if (we[i]) begin
                q[i] <= wd[i];
            end
        end
    end
endmodule

// File: rtl/rp_step.sv
module rp_step
    import regpair_pkg::*;
#(
    parameter int W = PAIR_W
) (
    input  logic [W-1:0] val,
    input  logic         down,
    output logic [W-1:0] res
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        res = down ? (val - ONE) : (val + ONE);
    end
endmodule

// File: rtl/rp_xseq.sv
module rp_xseq
    import regpair_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    start,
    output xphase_e phase,
    output logic    busy
);
    xphase_e nxt;

    always_comb begin
        unique case (phase)
            XS_IDLE: nxt = start ? XS_LOAD : XS_IDLE;
            XS_LOAD: nxt = XS_MOVE;
            XS_MOVE: nxt = XS_BACK;
            default: nxt = XS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= XS_IDLE;
        end else begin
            phase <= nxt;
        end
    end

    assign busy = (phase != XS_IDLE);
endmodule

// File: rtl/pair_regfile.sv
module pair_regfile
    import regpair_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  logic [2:0]  wr_sel,
    input  logic [7:0]  wr_data,
    input  logic [2:0]  rd_sel,
    output logic [7:0]  rd_data,
    input  logic        pw_en,
    input  logic [1:0]  pw_sel,
    input  logic [15:0] pw_data,
    input  logic [1:0]  pr_sel,
    output logic [15:0] pr_data,
    input  logic        step_en,
    input  logic [1:0]  step_sel,
    input  logic        step_dn,
    input  logic        xchg_start,
    output logic        busy,
    output logic [15:0] hl_ptr
);
    logic [NREG-1:0]            bank_we;
    logic [NREG-1:0][BYTE_W-1:0] bank_wd;
    logic [NREG-1:0][BYTE_W-1:0] bank_q;

    xphase_e   phase;
    logic      seq_busy;
    logic      accept;
    pair_t     step_src;
    pair_t     step_res;
    pair_upd_t upd;

    rp_bank #(.N(NREG), .W(BYTE_W)) u_bank (
        .clk (clk),
        .rst (rst),
        .we  (bank_we),
        .wd  (bank_wd),
        .q   (bank_q)
    );

    rp_xseq u_xseq (
        .clk   (clk),
        .rst   (rst),
        .start (xchg_start),
        .phase (phase),
        .busy  (seq_busy)
    );

    assign step_src = {bank_q[pair_hi(step_sel)], bank_q[pair_lo(step_sel)]};

    rp_step #(.W(PAIR_W)) u_step (
        .val  (step_src),
        .down (step_dn),
        .res  (step_res)
    );

    // New requests are taken only when idle and no exchange is starting.
    assign accept = (phase == XS_IDLE) && !xchg_start;

    // Pair-level winner among step and pair write.
    always_comb begin
        upd = '0;
        if (step_en && pair_code_ok(step_sel)) begin
            upd.hit = 1'b1;
            upd.sel = step_sel;
            upd.val = step_res;
        end else if (pw_en && pair_code_ok(pw_sel)) begin
            upd.hit = 1'b1;
            upd.sel = pw_sel;
            upd.val = pw_data;
        end
    end

    always_comb begin
        bank_we = '0;
        bank_wd = bank_q;
        unique case (phase)
            XS_LOAD: begin
                bank_we[pair_hi(PR_WZ)] = 1'b1;
                bank_we[pair_lo(PR_WZ)] = 1'b1;
                bank_wd[pair_hi(PR_WZ)] = bank_q[pair_hi(PR_DE)];
                bank_wd[pair_lo(PR_WZ)] = bank_q[pair_lo(PR_DE)];
            end
            XS_MOVE: begin
                bank_we[pair_hi(PR_DE)] = 1'b1;
                bank_we[pair_lo(PR_DE)] = 1'b1;
                bank_wd[pair_hi(PR_DE)] = bank_q[pair_hi(PR_HL)];
                bank_wd[pair_lo(PR_DE)] = bank_q[pair_lo(PR_HL)];
            end
            XS_BACK: begin
                bank_we[pair_hi(PR_HL)] = 1'b1;
                bank_we[pair_lo(PR_HL)] = 1'b1;
                bank_wd[pair_hi(PR_HL)] = bank_q[pair_hi(PR_WZ)];
                bank_wd[pair_lo(PR_HL)] = bank_q[pair_lo(PR_WZ)];
            end
            default: begin
                if (accept) begin
                    if (upd.hit) begin
                        bank_we[pair_hi(upd.sel)] = 1'b1;
                        bank_we[pair_lo(upd.sel)] = 1'b1;
                        bank_wd[pair_hi(upd.sel)] = upd.val[PAIR_W-1:BYTE_W];
                        bank_wd[pair_lo(upd.sel)] = upd.val[BYTE_W-1:0];
                    end else if (wr_en && byte_code_ok(wr_sel)) begin
                        bank_we[wr_sel] = 1'b1;
                        bank_wd[wr_sel] = wr_data;
                    end
                end
            end
        endcase
    end

    assign rd_data = byte_code_ok(rd_sel) ? bank_q[rd_sel] : '0;
    assign pr_data = pair_code_ok(pr_sel)
                   ? {bank_q[pair_hi(pr_sel)], bank_q[pair_lo(pr_sel)]} : '0;
    assign hl_ptr  = {bank_q[pair_hi(PR_HL)], bank_q[pair_lo(PR_HL)]};
    assign busy    = seq_busy;
endmodule

// File: rtl/pair_regfile_chk.sv
module pair_regfile_chk
    import regpair_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        wr_en,
    input logic [2:0]  wr_sel,
    input logic [7:0]  wr_data,
    input logic        pw_en,
    input logic [1:0]  pw_sel,
    input logic [15:0] pw_data,
    input logic        step_en,
    input logic [1:0]  step_sel,
    input logic        step_dn,
    input logic        xchg_start,
    input logic        busy,
    input logic [15:0] hl_ptr,
    input logic [NREG-1:0][BYTE_W-1:0] bank_q
);
    logic idle_take;
    assign idle_take = !busy && !xchg_start;

    a_r7_busy_three: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ##1 busy ##1 busy ##1 !busy);

    a_r7_swap_result: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (hl_ptr == $past({bank_q[IX_D], bank_q[IX_E]}, 3))
                     && ({bank_q[IX_D], bank_q[IX_E]} == $past(hl_ptr, 3)));

    a_r8_bc_frozen: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(bank_q[IX_B]) && $stable(bank_q[IX_C]));

    a_r8_start_blocks: assert property (@(posedge clk) disable iff (rst)
        (!busy && xchg_start) |=> busy && $stable(bank_q[IX_B])
                               && $stable(bank_q[IX_C]) && $stable(hl_ptr));

    a_r6_hl_step: assert property (@(posedge clk) disable iff (rst)
        (idle_take && step_en && step_sel == 2'd2)
        |=> hl_ptr == (step_dn ? $past(hl_ptr) - 16'd1 : $past(hl_ptr) + 16'd1));

    a_r2_byte_write_b: assert property (@(posedge clk) disable iff (rst)
        (idle_take && !step_en && !pw_en && wr_en && wr_sel == 3'd0)
        |=> bank_q[IX_B] == $past(wr_data));

    a_r2_bad_code: assert property (@(posedge clk) disable iff (rst)
        (idle_take && !step_en && !pw_en && wr_en && wr_sel[2:1] == 2'b11)
        |=> $stable(bank_q[IX_B]) && $stable(bank_q[IX_C]) && $stable(bank_q[IX_D])
         && $stable(bank_q[IX_E]) && $stable(hl_ptr));

    a_r3_pair_write: assert property (@(posedge clk) disable iff (rst)
        (idle_take && !step_en && pw_en && pw_sel == 2'd0)
        |=> {bank_q[IX_B], bank_q[IX_C]} == $past(pw_data));
endmodule

bind pair_regfile pair_regfile_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .pw_en      (pw_en),
    .pw_sel     (pw_sel),
    .pw_data    (pw_data),
    .step_en    (step_en),
    .step_sel   (step_sel),
    .step_dn    (step_dn),
    .xchg_start (xchg_start),
    .busy       (busy),
    .hl_ptr     (hl_ptr),
    .bank_q     (bank_q)
);

// File: tb/pair_regfile_bench.sv
module pair_regfile_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_sel = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_sel = '0;
    logic [7:0]  rd_data;
    logic        pw_en = 1'b0;
    logic [1:0]  pw_sel = '0;
    logic [15:0] pw_data = '0;
    logic [1:0]  pr_sel = '0;
    logic [15:0] pr_data;
    logic        step_en = 1'b0;
    logic [1:0]  step_sel = '0;
    logic        step_dn = 1'b0;
    logic        xchg_start = 1'b0;
    logic        busy;
    logic [15:0] hl_ptr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pair_regfile u_pair_regfile (
        .clk (clk), .rst (rst),
        .wr_en (wr_en), .wr_sel (wr_sel), .wr_data (wr_data),
        .rd_sel (rd_sel), .rd_data (rd_data),
        .pw_en (pw_en), .pw_sel (pw_sel), .pw_data (pw_data),
        .pr_sel (pr_sel), .pr_data (pr_data),
        .step_en (step_en), .step_sel (step_sel), .step_dn (step_dn),
        .xchg_start (xchg_start), .busy (busy), .hl_ptr (hl_ptr)
    );

    // op: 0 byte write, 1 pair write, 2 step up, 3 step down
    // fields: op[38:37] sel[36:34] data[33:18] chk_pair[17:16] expect[15:0]
    localparam int NV = 12;
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 3'd0, 16'h00AB, 2'd0, 16'hAB00},  // R2 B
        {2'd0, 3'd1, 16'h00CD, 2'd0, 16'hABCD},  // R2 C, R3 order
        {2'd1, 3'd1, 16'h1234, 2'd1, 16'h1234},  // R3 DE write
        {2'd0, 3'd4, 16'h00FF, 2'd2, 16'hFF00},  // R2 H
        {2'd0, 3'd5, 16'h00FF, 2'd2, 16'hFFFF},  // R2 L
        {2'd2, 3'd2, 16'h0000, 2'd2, 16'h0000},  // R6 wrap up
        {2'd3, 3'd2, 16'h0000, 2'd2, 16'hFFFF},  // R6 wrap down
        {2'd3, 3'd0, 16'h0000, 2'd0, 16'hABCC},  // R6 BC down
        {2'd0, 3'd6, 16'h0055, 2'd1, 16'h1234},  // R2 code 110 rejected
        {2'd1, 3'd3, 16'h9999, 2'd2, 16'hFFFF},  // R3 pair code 11 rejected
        {2'd2, 3'd3, 16'h0000, 2'd0, 16'hABCC},  // R3 step code 11 rejected
        {2'd0, 3'd3, 16'h0000, 2'd1, 16'h1200}   // R2 E
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        wr_en = 1'b0; pw_en = 1'b0; step_en = 1'b0; xchg_start = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=0", 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (2) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int p = 0; p < 3; p++) begin
            pr_sel = 2'(p);
            #1 check("R1 pair after reset", pr_data, 16'h0000);
        end
        check("R1 busy after reset", {15'd0, busy}, 16'd0);
        check("R4 pointer after reset", hl_ptr, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            unique case (VEC[i][38:37])
                2'd0: begin wr_en = 1'b1; wr_sel = VEC[i][36:34]; wr_data = VEC[i][25:18]; end
                2'd1: begin pw_en = 1'b1; pw_sel = VEC[i][35:34]; pw_data = VEC[i][33:18]; end
                default: begin
                    step_en = 1'b1; step_sel = VEC[i][35:34]; step_dn = VEC[i][37];
                end
            endcase
            @(negedge clk);
            idle_inputs();
            pr_sel = VEC[i][17:16];
            #1 check($sformatf("R2/R3/R6 vector %0d", i), pr_data, VEC[i][15:0]);
        end

        // R4 pointer mirrors HL
        check("R4 pointer", hl_ptr, 16'hFFFF);
        // R2 hidden codes and byte read
        rd_sel = 3'd6; #1 check("R2 read code 110", {8'd0, rd_data}, 16'h0000);
        rd_sel = 3'd4; #1 check("R2 read H", {8'd0, rd_data}, 16'h00FF);

        // R5 same-cycle read returns old value
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'h11; pr_sel = 2'd0;
        #1 check("R5 old value same cycle", pr_data, 16'hABCC);
        @(negedge clk);
        idle_inputs();
        #1 check("R5 new value next cycle", pr_data, 16'h11CC);

        // R9 priority: step beats pair write beats byte write
        @(negedge clk);
        step_en = 1'b1; step_sel = 2'd1; step_dn = 1'b0;
        pw_en = 1'b1; pw_sel = 2'd1; pw_data = 16'h5555;
        wr_en = 1'b1; wr_sel = 3'd3; wr_data = 8'h77;
        @(negedge clk);
        idle_inputs();
        pr_sel = 2'd1;
        #1 check("R9 step wins", pr_data, 16'h1201);
        @(negedge clk);
        pw_en = 1'b1; pw_sel = 2'd2; pw_data = 16'hFFFF;
        wr_en = 1'b1; wr_sel = 3'd5; wr_data = 8'h00;
        @(negedge clk);
        idle_inputs();
        pr_sel = 2'd2;
        #1 check("R9 pair write beats byte write", pr_data, 16'hFFFF);

        // R7/R8 exchange with competing traffic
        @(negedge clk);
        xchg_start = 1'b1;
        wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h99;   // R8 ignored on start cycle
        @(negedge clk);
        idle_inputs();
        check("R7 busy cycle 1", {15'd0, busy}, 16'd1);
        wr_en = 1'b1; wr_sel = 3'd0; wr_data = 8'hEE;   // R8 ignored while busy
        step_en = 1'b1; step_sel = 2'd2; step_dn = 1'b0;
        @(negedge clk);
        check("R7 busy cycle 2", {15'd0, busy}, 16'd1);
        xchg_start = 1'b1;                                // R8 restart ignored
        @(negedge clk);
        idle_inputs();
        check("R7 busy cycle 3", {15'd0, busy}, 16'd1);
        @(negedge clk);
        check("R7 busy falls after three", {15'd0, busy}, 16'd0);
        pr_sel = 2'd1;
        #1 check("R7 DE holds old HL", pr_data, 16'hFFFF);
        pr_sel = 2'd2;
        #1 check("R7 HL holds old DE", pr_data, 16'h1201);
        check("R4 pointer after swap", hl_ptr, 16'h1201);
        pr_sel = 2'd0;
        #1 check("R8 BC untouched by busy writes", pr_data, 16'h11CC);
        rd_sel = 3'd7;
        #1 check("R2 scratch byte hidden", {8'd0, rd_data}, 16'h0000);
        @(negedge clk);
        check("R8 restart during busy ignored", {15'd0, busy}, 16'd0);

        // R1 reset mid-run
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        pr_sel = 2'd2;
        #1 check("R1 HL after second reset", pr_data, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule